// File: doc/BRIEF.md
# Motor-Driver Serial Control Port with Status Flags

This block is the host-facing serial slave of a motor-driver controller. The host frames each transfer with an active-low select and a serial clock. Through that port it writes a DAC byte and two control bytes, and it reads back any of those bytes or an 8-bit status word. All pins are sampled in the system clock domain after two-flop synchronizers, and serial bits are taken on rising serial-clock edges. The analog comparators, the power stage and the current sensing sit outside the block and reach it as digital levels.

The status word tells the host three things. Two toggle bits confirm that writes actually landed. A framing-error flag reports frames with the wrong number of clock edges. The remaining bits describe the motor: current limit, chop blanking, back-EMF phase and the output-stage condition. The sticky bits clear when the host reads them. The block also owns the output-enable decision. The power stage stays tristated from reset until the host enables it, and it is forced back to tristate as soon as current limit appears while the block is in run mode.

Top module: `spc_port_top`

## Requirements
- R1: A frame is 16 rising serial-clock edges while the select is low, sent MSB first. Bit 15 is the direction (1 = read), bits 14:12 are the address, bits 11:8 are ignored and bits 7:0 are data. A write takes effect when the select rises. Address 0 is the DAC byte, 1 is control A, 2 is control B and 3 is the status word. A write to address 3 or to any address above 3 changes nothing, and a read of an address above 3 returns 0.
- R2: During a read frame, the data output carries the addressed byte MSB first. Bit 7 is valid after the 8th rising edge, and each later edge (9th to 15th) presents the next lower bit. The output is 0 whenever the select is high.
- R3: Status bit 0 inverts on every accepted write to the DAC address.
- R4: Status bit 1 inverts on every accepted write to control A or control B.
- R5: If the edge count between the select falling and rising differs from 16, status bit 2 (framing error) is set. Such a frame changes no register and flips no toggle bit.
- R6: Status bits 2, 3 and 4 are sticky. A well-formed read of the status address clears those of them that were reported as set in that read.
- R7: Status bit 4 is set whenever the current-limit input is high, whether the block is in start mode or run mode.
- R8: The tristate output is high while control A bit 0 (drive enable) is 0. Current limit seen while both control A bit 0 and control A bit 1 (run mode) are 1 sets a fault latch. That latch forces tristate and shows in status bit 7, and it clears on the next accepted write to control A. Status bit 6 mirrors the tristate output.
- R9: On every falling edge of the spindle clock, status bit 5 is set if the back-EMF comparator equals control B bit 0 and cleared otherwise. It is not sticky.
- R10: Status bit 3 is set when the blanking comparator and the PWM on-delay window are high together. Blanking alone does not set it.
- R11: After reset, all registers, toggles and flags are 0, the data output is 0 and the tristate output is 1, so status reads 0x40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, data taken on rising edges |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| spin_clk | input | 1 | Spindle commutation clock |
| bemf_cmp | input | 1 | Back-EMF comparator level |
| blank_cmp | input | 1 | Chop-blanking comparator level |
| ondly_win | input | 1 | PWM on-delay window active |
| ilim_in | input | 1 | Current-limit comparator level |
| dac_byte | output | 8 | Stored DAC byte |
| ctl_a | output | 8 | Control register A |
| ctl_b | output | 8 | Control register B |
| drive_hiz | output | 1 | Power-stage tristate request |

## Verification
The embedded properties watch several behaviours on every cycle. A bad-length frame must leave every register and toggle untouched and must raise the framing flag. Current limit in run mode must produce tristate on the next cycle. The phase bit must follow the comparator at each spindle-clock fall, coincident blanking and on-delay must set the chop flag, and the data output must rest low between frames. The bench scenarios are what show that the read-out bit order is right, that toggles confirm writes over a sequence, that reads clear only what they reported, and that the fault latch releases on a control write. They also show that writes to read-only or unused addresses are ignored.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int PAD_W      = 4;
    localparam int FRAME_BITS = 1 + ADDR_W + PAD_W + DATA_W;
    localparam int HEAD_BITS  = FRAME_BITS - DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int NUM_WR     = 3;
    localparam int STICKY_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DAC  = 3'd0,
        REG_CTLA = 3'd1,
        REG_CTLB = 3'd2,
        REG_STAT = 3'd3
    } reg_addr_e;

    // Serial word as it arrives, MSB first.
    typedef struct packed {
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [PAD_W-1:0]  pad;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Event emitted when the select rises.
    typedef struct packed {
        logic              done;
        logic              ok;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_evt_t;

    typedef struct packed {
        logic fault;
        logic hiz;
        logic phase_ok;
        logic ilim;
        logic chop;
        logic tx_err;
        logic ctl_tgl;
        logic dac_tgl;
    } status_t;

    function automatic logic hits(logic [ADDR_W-1:0] a, reg_addr_e r);
        return a == r;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
        return (&c) ? c : c + 1'b1;
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spc_frame.sv
module spc_frame
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load_req,
    output frame_evt_t        evt,
    output logic              sdo
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HEAD_BITS - 1);

    logic                  cs_d, sck_d;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sr;
    logic [DATA_W-1:0]     out_sr;
    logic                  sck_rise, cs_fall, cs_rise, in_frame;

    assign sck_rise = sck_s & ~sck_d;
    assign cs_fall  = ~cs_n_s & cs_d;
    assign cs_rise  = cs_n_s & ~cs_d;
    assign in_frame = ~cs_n_s;

    // Before the edge that completes the header, the direction bit and the
    // address sit just below the next shift position.
    assign rd_addr  = sr[HEAD_BITS-3 -: ADDR_W];
    assign load_req = sck_rise & in_frame & (cnt == CNT_LOAD) & sr[HEAD_BITS-2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b1;
            sck_d  <= 1'b0;
            cnt    <= '0;
            sr     <= '0;
            out_sr <= '0;
        end else begin
            cs_d  <= cs_n_s;
            sck_d <= sck_s;
            if (cs_fall) begin
                cnt    <= '0;
                sr     <= '0;
                out_sr <= '0;
            end else if (cs_rise) begin
                out_sr <= '0;
            end else if (in_frame && sck_rise) begin
                sr  <= {sr[FRAME_BITS-2:0], sdi_s};
                cnt <= sat_inc(cnt);
                if (load_req)
                    out_sr <= rd_word;
                else if (cnt > CNT_LOAD)
                    out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign evt.done = cs_rise;
    assign evt.ok   = (cnt == CNT_FULL);
    assign evt.rw   = sr[FRAME_BITS-1];
    assign evt.addr = sr[FRAME_BITS-2 -: ADDR_W];
    assign evt.data = sr[DATA_W-1:0];
    assign sdo      = out_sr[DATA_W-1];

    // R2: the data line rests low between frames
    a_r2_sdo_idle_low: assert property (@(posedge clk) disable iff (rst)
        (cs_n_s && cs_d) |-> !sdo);

    // R1: every new frame starts counting from zero
    a_r1_count_restart: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (cnt == '0));
endmodule

// File: rtl/spc_regs.sv
module spc_regs
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_evt_t        evt,
    input  logic [ADDR_W-1:0] rd_addr,
    input  status_t           stat,
    output logic [DATA_W-1:0] dac_q,
    output logic [DATA_W-1:0] ctl_a_q,
    output logic [DATA_W-1:0] ctl_b_q,
    output logic              dac_tgl,
    output logic              ctl_tgl,
    output logic              ctla_wr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] bank [NUM_WR];
    logic              wr_ok, wr_dac, wr_ctl;

    assign wr_ok   = evt.done & evt.ok & ~evt.rw;
    assign wr_dac  = wr_ok & hits(evt.addr, REG_DAC);
    assign ctla_wr = wr_ok & hits(evt.addr, REG_CTLA);
    assign wr_ctl  = ctla_wr | (wr_ok & hits(evt.addr, REG_CTLB));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WR; i++) bank[i] <= '0;
            dac_tgl <= 1'b0;
            ctl_tgl <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_WR; i++)
                if (wr_ok && evt.addr == ADDR_W'(i)) bank[i] <= evt.data;
            if (wr_dac) dac_tgl <= ~dac_tgl;
            if (wr_ctl) ctl_tgl <= ~ctl_tgl;
        end
    end

    assign dac_q   = bank[int'(REG_DAC)];
    assign ctl_a_q = bank[int'(REG_CTLA)];
    assign ctl_b_q = bank[int'(REG_CTLB)];

    always_comb begin
        case (rd_addr)
            REG_DAC:  rd_word = dac_q;
            REG_CTLA: rd_word = ctl_a_q;
            REG_CTLB: rd_word = ctl_b_q;
            REG_STAT: rd_word = stat;
            default:  rd_word = '0;
        endcase
    end

    // R5: a frame with a bad edge count leaves all storage alone
    a_r5_bad_frame_inert: assert property (@(posedge clk) disable iff (rst)
        (evt.done && !evt.ok) |=> ($stable(dac_q) && $stable(ctl_a_q) &&
                                   $stable(ctl_b_q) && $stable(dac_tgl) &&
                                   $stable(ctl_tgl)));

    // R3: accepted DAC write inverts its confirmation bit
    a_r3_dac_toggle: assert property (@(posedge clk) disable iff (rst)
        (evt.done && evt.ok && !evt.rw && evt.addr == REG_DAC) |=> (dac_tgl != $past(dac_tgl)));

    // R4: control writes never disturb the DAC confirmation bit
    a_r4_ctl_toggle: assert property (@(posedge clk) disable iff (rst)
        (evt.done && evt.ok && !evt.rw && (evt.addr == REG_CTLA || evt.addr == REG_CTLB))
            |=> ((ctl_tgl != $past(ctl_tgl)) && $stable(dac_tgl)));
endmodule

// File: rtl/spc_status.sv
module spc_status
    import spc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bad_frame,
    input  logic    stat_load,
    input  logic    stat_clear,
    input  logic    drive_en,
    input  logic    run_mode,
    input  logic    bemf_pol,
    input  logic    dac_tgl,
    input  logic    ctl_tgl,
    input  logic    ctla_wr,
    input  logic    ilim_s,
    input  logic    spin_s,
    input  logic    bemf_s,
    input  logic    blank_s,
    input  logic    ondly_s,
    output status_t stat,
    output logic    hiz
);
    // Sticky order: {current limit, chop blanking, framing error}
    logic [STICKY_W-1:0] sticky, reported, set_v, clr_v;
    logic                spin_d, phase_ok, kill, spin_fall;

    assign spin_fall = ~spin_s & spin_d;
    assign set_v     = {ilim_s, blank_s & ondly_s, bad_frame};
    assign clr_v     = stat_clear ? reported : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky   <= '0;
            reported <= '0;
            spin_d   <= 1'b0;
            phase_ok <= 1'b0;
            kill     <= 1'b0;
        end else begin
            sticky <= (sticky & ~clr_v) | set_v;
            if (stat_load) reported <= sticky;
            spin_d <= spin_s;
            if (spin_fall) phase_ok <= (bemf_s == bemf_pol);
            if (ilim_s && drive_en && run_mode) kill <= 1'b1;
            else if (ctla_wr)                   kill <= 1'b0;
        end
    end

    assign hiz = ~drive_en | kill;

    assign stat.fault    = kill;
    assign stat.hiz      = hiz;
    assign stat.phase_ok = phase_ok;
    assign stat.ilim     = sticky[2];
    assign stat.chop     = sticky[1];
    assign stat.tx_err   = sticky[0];
    assign stat.ctl_tgl  = ctl_tgl;
    assign stat.dac_tgl  = dac_tgl;

    // R5: a bad frame raises the framing flag
    a_r5_tx_err_sets: assert property (@(posedge clk) disable iff (rst)
        bad_frame |=> stat.tx_err);

    // R7: current limit is recorded in any mode
    a_r7_ilim_recorded: assert property (@(posedge clk) disable iff (rst)
        ilim_s |=> stat.ilim);

    // R8: current limit in run mode tristates the stage on the next cycle
    a_r8_run_ilim_hiz: assert property (@(posedge clk) disable iff (rst)
        (ilim_s && drive_en && run_mode) |=> (hiz && stat.fault));

    // R9: phase bit follows the comparator at each spindle-clock fall
    a_r9_phase_sample: assert property (@(posedge clk) disable iff (rst)
        spin_fall |=> (phase_ok == $past(bemf_s == bemf_pol)));

    // R10: coincident blanking and on-delay marks the chop flag
    a_r10_chop_sets: assert property (@(posedge clk) disable iff (rst)
        (blank_s && ondly_s) |=> stat.chop);
endmodule

// File: rtl/spc_port_top.sv
module spc_port_top
    import spc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    input  logic              spin_clk,
    input  logic              bemf_cmp,
    input  logic              blank_cmp,
    input  logic              ondly_win,
    input  logic              ilim_in,
    output logic [DATA_W-1:0] dac_byte,
    output logic [DATA_W-1:0] ctl_a,
    output logic [DATA_W-1:0] ctl_b,
    output logic              drive_hiz
);
    localparam int         N_IN     = 8;
    localparam logic [N_IN-1:0] IN_IDLE = 8'b1000_0000;

    logic [N_IN-1:0]   raw_in, syn_in;
    logic              cs_n_s, sck_s, sdi_s, spin_s, bemf_s, blank_s, ondly_s, ilim_s;
    frame_evt_t        evt;
    logic [ADDR_W-1:0] rd_addr;
    logic              load_req;
    logic [DATA_W-1:0] rd_word;
    status_t           stat;
    logic              dac_tgl, ctl_tgl, ctla_wr;
    logic              bad_frame, stat_load, stat_clear;

    assign raw_in = {cs_n, sck, sdi, spin_clk, bemf_cmp, blank_cmp, ondly_win, ilim_in};

    spc_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign {cs_n_s, sck_s, sdi_s, spin_s, bemf_s, blank_s, ondly_s, ilim_s} = syn_in;

    spc_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_n_s),
        .sck_s    (sck_s),
        .sdi_s    (sdi_s),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .load_req (load_req),
        .evt      (evt),
        .sdo      (sdo)
    );

    spc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_addr (rd_addr),
        .stat    (stat),
        .dac_q   (dac_byte),
        .ctl_a_q (ctl_a),
        .ctl_b_q (ctl_b),
        .dac_tgl (dac_tgl),
        .ctl_tgl (ctl_tgl),
        .ctla_wr (ctla_wr),
        .rd_word (rd_word)
    );

    assign bad_frame  = evt.done & ~evt.ok;
    assign stat_load  = load_req & hits(rd_addr, REG_STAT);
    assign stat_clear = evt.done & evt.ok & evt.rw & hits(evt.addr, REG_STAT);

    spc_status u_status (
        .clk        (clk),
        .rst        (rst),
        .bad_frame  (bad_frame),
        .stat_load  (stat_load),
        .stat_clear (stat_clear),
        .drive_en   (ctl_a[0]),
        .run_mode   (ctl_a[1]),
        .bemf_pol   (ctl_b[0]),
        .dac_tgl    (dac_tgl),
        .ctl_tgl    (ctl_tgl),
        .ctla_wr    (ctla_wr),
        .ilim_s     (ilim_s),
        .spin_s     (spin_s),
        .bemf_s     (bemf_s),
        .blank_s    (blank_s),
        .ondly_s    (ondly_s),
        .stat       (stat),
        .hiz        (drive_hiz)
    );
endmodule

// File: tb/tb_spc_port_top.sv
module tb_spc_port_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, sck, sdi, spin_clk, bemf_cmp, blank_cmp, ondly_win, ilim_in;
    logic       sdo, drive_hiz;
    logic [7:0] dac_byte, ctl_a, ctl_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    always #10 clk = ~clk;

    spc_port_top dut (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdi       (sdi),
        .sdo       (sdo),
        .spin_clk  (spin_clk),
        .bemf_cmp  (bemf_cmp),
        .blank_cmp (blank_cmp),
        .ondly_win (ondly_win),
        .ilim_in   (ilim_in),
        .dac_byte  (dac_byte),
        .ctl_a     (ctl_a),
        .ctl_b     (ctl_b),
        .drive_hiz (drive_hiz)
    );

    // {frame word, expected read byte}; read frames have bit 15 set
    localparam int NVEC = 9;
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h00A5, 8'h00},
        {16'h8000, 8'hA5},
        {16'h203C, 8'h00},
        {16'hA000, 8'h3C},
        {16'h1000, 8'h00},
        {16'h9000, 8'h00},
        {16'h50FF, 8'h00},
        {16'hD000, 8'h00},
        {16'h8000, 8'hA5}
    };

    localparam logic [15:0] RD_STAT = 16'hB000;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [15:0] w, input int nedges, output logic [7:0] rd);
        rd = 8'h00;
        cs_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < nedges; k++) begin
            sdi = (k < 16) ? w[15-k] : 1'b0;
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            if (k >= 7 && k <= 14) rd[14-k] = sdo;
            sck = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        sdi  = 1'b0;
        wait_clk(8);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] r;
        send_frame(RD_STAT, 16, r);
        check(req, r, exp);
    endtask

    task automatic write_frame(input logic [15:0] w);
        logic [7:0] r;
        send_frame(w, 16, r);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        wait_clk(4);
        sig = 1'b0;
        wait_clk(6);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1;
        cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
        spin_clk = 1'b0; bemf_cmp = 1'b0; blank_cmp = 1'b0; ondly_win = 1'b0; ilim_in = 1'b0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R11: reset state
        check("R11 hiz", {7'b0, drive_hiz}, 8'h01);
        check("R11 sdo", {7'b0, sdo}, 8'h00);
        check("R11 dac", dac_byte, 8'h00);
        check("R11 ctl_a", ctl_a, 8'h00);
        check("R11 ctl_b", ctl_b, 8'h00);
        read_status("R11 status", 8'h40);

        // R1 / R2: table of writes and read-backs
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VEC[i][23:8], 16, r);
            if (VEC[i][23]) check($sformatf("R1/R2 vec%0d read", i), r, VEC[i][7:0]);
        end
        check("R1 dac port", dac_byte, 8'hA5);
        check("R1 ctl_b port", ctl_b, 8'h3C);
        check("R2 sdo idle", {7'b0, sdo}, 8'h00);
        // R3 one DAC write; R4 two control writes cancel
        read_status("R3/R4 toggles", 8'h41);

        // R8: drive enable releases tristate
        write_frame(16'h1001);
        check("R8 enabled hiz", {7'b0, drive_hiz}, 8'h00);
        read_status("R4 ctl toggle", 8'h03);

        // R1: write to status address ignored
        write_frame(16'h30FF);
        read_status("R1 status write ignored", 8'h03);

        // R5: short frame
        send_frame(16'h0011, 15, r);
        check("R5 short no write", dac_byte, 8'hA5);
        read_status("R5 short flag", 8'h07);
        read_status("R6 cleared", 8'h03);

        // R5: long frame
        send_frame(16'h0022, 17, r);
        check("R5 long no write", dac_byte, 8'hA5);
        read_status("R5 long flag", 8'h07);
        read_status("R6 cleared again", 8'h03);

        // R10: blanking alone, then coincident
        pulse(blank_cmp);
        read_status("R10 blank alone", 8'h03);
        ondly_win = 1'b1;
        pulse(blank_cmp);
        ondly_win = 1'b0;
        read_status("R10 chop set", 8'h0B);
        read_status("R6 chop cleared", 8'h03);

        // R7 / R8: current limit in start mode only flags
        pulse(ilim_in);
        check("R8 start mode stays driven", {7'b0, drive_hiz}, 8'h00);
        read_status("R7 ilim start", 8'h13);
        read_status("R6 ilim cleared", 8'h03);

        // R9: phase sampling, polarity from ctl_b bit 0 = 0
        bemf_cmp = 1'b0;
        pulse(spin_clk);
        read_status("R9 phase good", 8'h23);
        read_status("R9 not sticky", 8'h23);
        bemf_cmp = 1'b1;
        pulse(spin_clk);
        bemf_cmp = 1'b0;
        read_status("R9 phase bad", 8'h03);

        // R8: run mode fault
        write_frame(16'h1003);
        check("R8 run enabled", {7'b0, drive_hiz}, 8'h00);
        read_status("R4 run write", 8'h01);
        pulse(ilim_in);
        check("R8 run fault hiz", {7'b0, drive_hiz}, 8'h01);
        read_status("R8 fault status", 8'hD1);
        read_status("R6 fault keeps latch", 8'hC1);
        write_frame(16'h1001);
        check("R8 fault released", {7'b0, drive_hiz}, 8'h00);
        read_status("R8 after release", 8'h03);

        finish_run();
    end
endmodule